// File: doc/BRIEF.md
# Wide-Line SECDED Read Corrector and Check Generator

This block sits on the path between a wide embedded DRAM and a line cache. A stored word is one cache line split into eight independent 64-bit lanes. Each lane carries one check byte, and sixteen bits of the word are left unused. On the write side the block builds all eight check bytes in a single registered stage and zeroes the unused bits. On the read side it decodes every lane in parallel with an extended Hamming single-error-correct, double-error-detect code. It repairs any single flipped bit, whether that bit lies in the data or in the check byte, and hands the clean line and its repaired check bytes to the cache one cycle later.

When any lane of a line needed a repair, the block raises a dirty indication. The cache then keeps the line marked modified, and the corrected contents eventually reach the DRAM again. An error that the code can detect but cannot repair is passed through untouched with its own flag. The two error classes each set their own sticky status bit and drive their own interrupt line, and each line has a mask input. The first error seen after software clears both status bits is recorded as a lane number and a syndrome for diagnosis.

Top module: `wideline_ecc`

## Requirements
- R1: Word layout: data lane k sits in bits [64k+63:64k] of [511:0], its check byte in bits [512+8k+7:512+8k], and bits [591:576] are spare. A write is presented on `wr_word` with `wr_valid` high one clock after `wr_en`, with the spare bits zero. `wr_word` holds its value while `wr_en` is low.
- R2: Data bit i of a lane occupies the (i+1)-th non-power-of-two codeword position counting up from 3 (3,5,6,7,9,...,71). Check bit j (j<7) is the XOR of the data bits whose position has bit j set. Check bit 7 makes the XOR of all 64 data bits and all 8 check bits equal zero.
- R3: A read of a word with no errors returns its data and check bytes unchanged on `out_data`/`out_chk` with `out_valid` one clock after `rd_valid`, with `out_dirty` and `out_uncorr` low. The outputs hold while `rd_valid` is low.
- R4: A single flipped data bit in any lane, in any number of lanes at once, is restored in `out_data`, and `out_dirty` is high.
- R5: A single flipped check bit, including check bit 7, leaves the data unaltered. It is restored in `out_chk`, and `out_dirty` is high.
- R6: A lane with a double error (even overall parity, nonzero syndrome), or with odd overall parity and a syndrome that names no codeword position, passes through unaltered, raises `out_uncorr`, and does not by itself raise `out_dirty`.
- R7: `sbe_status` and `dbe_status` are set by a read that contains a correctable or uncorrectable lane respectively. Each stays set until its clear input is high. When a clear and a new error arrive together, the error wins.
- R8: `irq_sbe` equals `sbe_status` AND NOT `mask_sbe`, and `irq_dbe` does the same with its own pair. The masks never change the status bits.
- R9: When a read contains an error and both status bits are clear before it, `err_lane` takes the lowest erroneous lane index and `err_syn` takes {overall parity, 7-bit syndrome} of that lane. Otherwise both hold.
- R10: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Line to encode is present |
| wr_data | input | 512 | Line data to encode |
| wr_word | output | 592 | Encoded word for the DRAM |
| wr_valid | output | 1 | `wr_word` was loaded this cycle |
| rd_valid | input | 1 | Raw DRAM word is present |
| rd_word | input | 592 | Raw word read from the DRAM |
| out_valid | output | 1 | Corrected line was loaded this cycle |
| out_data | output | 512 | Corrected line data for the cache |
| out_chk | output | 64 | Corrected check bytes |
| out_dirty | output | 1 | Line needed a repair; cache must mark it dirty |
| out_uncorr | output | 1 | Line holds an uncorrectable lane |
| mask_sbe | input | 1 | Masks the correctable-error interrupt |
| mask_dbe | input | 1 | Masks the uncorrectable-error interrupt |
| clr_sbe | input | 1 | Clears the correctable-error status |
| clr_dbe | input | 1 | Clears the uncorrectable-error status |
| sbe_status | output | 1 | Sticky correctable-error status |
| dbe_status | output | 1 | Sticky uncorrectable-error status |
| err_lane | output | 3 | Lane of the first recorded error |
| err_syn | output | 8 | Syndrome of the first recorded error |
| irq_sbe | output | 1 | Correctable-error interrupt |
| irq_dbe | output | 1 | Uncorrectable-error interrupt |

## Verification
The assertions check the following on every cycle:
- the one-cycle latency of both paths;
- that a dirty or uncorrectable line always leaves its status bit set;
- that a status bit rises only after a read and survives until it is cleared;
- that the recorded lane and syndrome stay frozen while any status bit is set.

Only the bench's scenarios can show whether the right bit was repaired, and whether check-bit flips leave the data alone. The same holds for lane priority within one line, error-over-clear precedence, and masking. The bench does this by comparing every output against a positional-XOR model on every clock.

// File: rtl/wle_pkg.sv
package wle_pkg;

    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_DATA,
        CLS_CHECK,
        CLS_DOUBLE
    } err_cls_e;

    // Codeword position of data bit idx: the idx-th non-power-of-two from 3 upward.
    function automatic int data_position(int idx);
        int n;
        n = 0;
        for (int p = 3; p < 65536; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == idx) return p;
                n++;
            end
        end
        return 0;
    endfunction

    function automatic logic pos_has_bit(int idx, int b);
        int p;
        p = data_position(idx);
        return p[b];
    endfunction

    function automatic logic is_pow2(int v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/wle_lane_enc.sv
module wle_lane_enc
    import wle_pkg::*;
#(
    parameter int DW = 64,
    parameter int CW = 8
) (
    input  logic [DW-1:0] d,
    output logic [CW-1:0] c
);
    localparam int HB = CW - 1;

    always_comb begin
        c = '0;
        for (int j = 0; j < HB; j++) begin
            for (int i = 0; i < DW; i++) begin
                if (pos_has_bit(i, j)) c[j] = c[j] ^ d[i];
            end
        end
        c[HB] = ^{d, c[HB-1:0]};
    end

endmodule

// File: rtl/wle_lane_dec.sv
module wle_lane_dec
    import wle_pkg::*;
#(
    parameter int DW = 64,
    parameter int CW = 8
) (
    input  logic [DW-1:0] d_in,
    input  logic [CW-1:0] c_in,
    output logic [DW-1:0] d_out,
    output logic [CW-1:0] c_out,
    output logic [CW-1:0] syn,
    output err_cls_e      cls
);
    localparam int HB = CW - 1;

    logic [HB-1:0] s;
    logic          odd;
    logic          data_hit;

    always_comb begin
        s = c_in[HB-1:0];
        for (int j = 0; j < HB; j++) begin
            for (int i = 0; i < DW; i++) begin
                if (pos_has_bit(i, j)) s[j] = s[j] ^ d_in[i];
            end
        end
        odd = ^{d_in, c_in};

        d_out    = d_in;
        c_out    = c_in;
        data_hit = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (odd && (int'(s) == data_position(i))) begin
                d_out[i] = ~d_in[i];
                data_hit = 1'b1;
            end
        end
        if (odd && (s == '0)) c_out[HB] = ~c_in[HB];
        for (int j = 0; j < HB; j++) begin
            if (odd && (int'(s) == (1 << j))) c_out[j] = ~c_in[j];
        end

        if (!odd && (s == '0))                             cls = CLS_NONE;
        else if (odd && ((s == '0) || is_pow2(int'(s))))   cls = CLS_CHECK;
        else if (data_hit)                                 cls = CLS_DATA;
        else                                               cls = CLS_DOUBLE;

        syn = {odd, s};
    end

endmodule

// File: rtl/wideline_ecc.sv
module wideline_ecc
    import wle_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DW    = 64,
    parameter int CW    = 8,
    parameter int SPARE = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [LANES*DW-1:0]         wr_data,
    output logic [LANES*(DW+CW)+SPARE-1:0] wr_word,
    output logic                        wr_valid,
    input  logic                        rd_valid,
    input  logic [LANES*(DW+CW)+SPARE-1:0] rd_word,
    output logic                        out_valid,
    output logic [LANES*DW-1:0]         out_data,
    output logic [LANES*CW-1:0]         out_chk,
    output logic                        out_dirty,
    output logic                        out_uncorr,
    input  logic                        mask_sbe,
    input  logic                        mask_dbe,
    input  logic                        clr_sbe,
    input  logic                        clr_dbe,
    output logic                        sbe_status,
    output logic                        dbe_status,
    output logic [$clog2(LANES)-1:0]    err_lane,
    output logic [CW-1:0]               err_syn,
    output logic                        irq_sbe,
    output logic                        irq_dbe
);
    localparam int DATA_W = LANES * DW;
    localparam int CHK_W  = LANES * CW;
    localparam int WORD_W = DATA_W + CHK_W + SPARE;
    localparam int LIDX_W = $clog2(LANES);

    typedef struct packed {
        logic              wr_valid;
        logic [WORD_W-1:0] wr_word;
        logic              out_valid;
        logic [DATA_W-1:0] out_data;
        logic [CHK_W-1:0]  out_chk;
        logic              out_dirty;
        logic              out_uncorr;
        logic              sbe;
        logic              dbe;
        logic [LIDX_W-1:0] err_lane;
        logic [CW-1:0]     err_syn;
    } state_t;

    state_t st_d, st_q;

    logic [CHK_W-1:0]  enc_chk;
    logic [DATA_W-1:0] fix_data;
    logic [CHK_W-1:0]  fix_chk;
    logic [CW-1:0]     lane_syn [LANES];
    err_cls_e          lane_cls [LANES];
    logic [LANES-1:0]  lane_fix;
    logic [LANES-1:0]  lane_dbl;
    logic              unused_spare;

    assign unused_spare = ^rd_word[WORD_W-1 -: SPARE];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        wle_lane_enc #(.DW(DW), .CW(CW)) u_enc (
            .d (wr_data[g*DW +: DW]),
            .c (enc_chk[g*CW +: CW])
        );
        wle_lane_dec #(.DW(DW), .CW(CW)) u_dec (
            .d_in  (rd_word[g*DW +: DW]),
            .c_in  (rd_word[DATA_W + g*CW +: CW]),
            .d_out (fix_data[g*DW +: DW]),
            .c_out (fix_chk[g*CW +: CW]),
            .syn   (lane_syn[g]),
            .cls   (lane_cls[g])
        );
        assign lane_fix[g] = (lane_cls[g] == CLS_DATA) || (lane_cls[g] == CLS_CHECK);
        assign lane_dbl[g] = (lane_cls[g] == CLS_DOUBLE);
    end

    logic              any_fix, any_dbl;
    logic [LIDX_W-1:0] first_lane;
    logic [CW-1:0]     first_syn;

    always_comb begin
        any_fix    = |lane_fix;
        any_dbl    = |lane_dbl;
        first_lane = '0;
        first_syn  = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (lane_fix[k] || lane_dbl[k]) begin
                first_lane = LIDX_W'(k);
                first_syn  = lane_syn[k];
            end
        end

        st_d          = st_q;
        st_d.wr_valid = wr_en;
        if (wr_en) st_d.wr_word = {{SPARE{1'b0}}, enc_chk, wr_data};

        st_d.out_valid = rd_valid;
        if (rd_valid) begin
            st_d.out_data   = fix_data;
            st_d.out_chk    = fix_chk;
            st_d.out_dirty  = any_fix;
            st_d.out_uncorr = any_dbl;
        end

        if (rd_valid && (any_fix || any_dbl) && !st_q.sbe && !st_q.dbe) begin
            st_d.err_lane = first_lane;
            st_d.err_syn  = first_syn;
        end
        st_d.sbe = (st_q.sbe && !clr_sbe) || (rd_valid && any_fix);
        st_d.dbe = (st_q.dbe && !clr_dbe) || (rd_valid && any_dbl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_word    = st_q.wr_word;
    assign wr_valid   = st_q.wr_valid;
    assign out_valid  = st_q.out_valid;
    assign out_data   = st_q.out_data;
    assign out_chk    = st_q.out_chk;
    assign out_dirty  = st_q.out_dirty;
    assign out_uncorr = st_q.out_uncorr;
    assign sbe_status = st_q.sbe;
    assign dbe_status = st_q.dbe;
    assign err_lane   = st_q.err_lane;
    assign err_syn    = st_q.err_syn;
    assign irq_sbe    = st_q.sbe && !mask_sbe;
    assign irq_dbe    = st_q.dbe && !mask_dbe;

    assert_write_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> wr_valid);
    assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> out_valid);
    assert_dirty_has_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dirty) |-> sbe_status);
    assert_uncorr_has_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_uncorr) |-> dbe_status);
    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sbe_status && !clr_sbe) |=> sbe_status);
    assert_status_from_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbe_status) |-> $past(rd_valid));
    assert_capture_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sbe_status || dbe_status) |=> ($stable(err_lane) && $stable(err_syn)));

endmodule

// File: tb/sim_wideline_ecc.sv
module sim_wideline_ecc;
    localparam int WW = 592;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [511:0]   wr_data = '0;
    logic [WW-1:0]  wr_word;
    logic           wr_valid;
    logic           rd_valid = 1'b0;
    logic [WW-1:0]  rd_word = '0;
    logic           out_valid;
    logic [511:0]   out_data;
    logic [63:0]    out_chk;
    logic           out_dirty, out_uncorr;
    logic           mask_sbe = 1'b0, mask_dbe = 1'b0, clr_sbe = 1'b0, clr_dbe = 1'b0;
    logic           sbe_status, dbe_status;
    logic [2:0]     err_lane;
    logic [7:0]     err_syn;
    logic           irq_sbe, irq_dbe;

    always #2 clk = ~clk;

    wideline_ecc u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_word(wr_word), .wr_valid(wr_valid), .rd_valid(rd_valid),
        .rd_word(rd_word), .out_valid(out_valid), .out_data(out_data),
        .out_chk(out_chk), .out_dirty(out_dirty), .out_uncorr(out_uncorr),
        .mask_sbe(mask_sbe), .mask_dbe(mask_dbe), .clr_sbe(clr_sbe),
        .clr_dbe(clr_dbe), .sbe_status(sbe_status), .dbe_status(dbe_status),
        .err_lane(err_lane), .err_syn(err_syn), .irq_sbe(irq_sbe), .irq_dbe(irq_dbe)
    );

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;
    int pos_of [64];
    int idx_at [128];

    initial begin
        int n;
        n = 0;
        for (int p = 0; p < 128; p++) idx_at[p] = -1;
        for (int p = 3; p < 128 && n < 64; p++) begin
            if ((p & (p - 1)) != 0) begin
                pos_of[n] = p;
                idx_at[p] = n;
                n++;
            end
        end
    end

    task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // positional-XOR code model
    function automatic logic [7:0] code_byte(input logic [63:0] d);
        logic [6:0] s;
        s = '0;
        for (int i = 0; i < 64; i++) if (d[i]) s = s ^ 7'(pos_of[i]);
        return {(^d) ^ (^s), s};
    endfunction

    function automatic logic [WW-1:0] build(input logic [511:0] d);
        logic [WW-1:0] w;
        w = '0;
        w[511:0] = d;
        for (int l = 0; l < 8; l++) w[512 + 8*l +: 8] = code_byte(d[64*l +: 64]);
        return w;
    endfunction

    // expected state
    logic           e_wv, e_ov, e_dirty, e_unc, e_sbe, e_dbe;
    logic [WW-1:0]  e_ww;
    logic [511:0]   e_od;
    logic [63:0]    e_oc;
    logic [2:0]     e_lane;
    logic [7:0]     e_syn;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_wv = 0; e_ov = 0; e_dirty = 0; e_unc = 0; e_sbe = 0; e_dbe = 0;
            e_ww = '0; e_od = '0; e_oc = '0; e_lane = '0; e_syn = '0;
        end else begin
            logic fx, db, got;
            logic [2:0] fl;
            logic [7:0] fs;
            fx = 0; db = 0; got = 0; fl = '0; fs = '0;
            e_wv = wr_en;
            if (wr_en) e_ww = build(wr_data);
            if (rd_valid) begin
                for (int l = 0; l < 8; l++) begin
                    logic [63:0] d;
                    logic [7:0] c;
                    logic [6:0] s;
                    logic odd, lf, ld;
                    d = rd_word[64*l +: 64];
                    c = rd_word[512 + 8*l +: 8];
                    s = '0;
                    for (int i = 0; i < 64; i++) if (d[i]) s = s ^ 7'(pos_of[i]);
                    for (int j = 0; j < 7; j++) if (c[j]) s = s ^ 7'(1 << j);
                    odd = ^{d, c};
                    lf = 0; ld = 0;
                    if (!odd && s == 0) begin end
                    else if (odd && s == 0) begin c[7] = ~c[7]; lf = 1; end
                    else if (odd && ((s & (s - 7'd1)) == 0)) begin
                        for (int j = 0; j < 7; j++) if (s == 7'(1 << j)) c[j] = ~c[j];
                        lf = 1;
                    end else if (odd && idx_at[s] >= 0) begin
                        d[idx_at[s]] = ~d[idx_at[s]];
                        lf = 1;
                    end else ld = 1;
                    e_od[64*l +: 64] = d;
                    e_oc[8*l +: 8]   = c;
                    if ((lf || ld) && !got) begin got = 1; fl = 3'(l); fs = {odd, s}; end
                    fx = fx | lf;
                    db = db | ld;
                end
                e_dirty = fx;
                e_unc   = db;
            end
            e_ov = rd_valid;
            if (rd_valid && got && !e_sbe && !e_dbe) begin e_lane = fl; e_syn = fs; end
            e_sbe = (e_sbe && !clr_sbe) || (rd_valid && fx);
            e_dbe = (e_dbe && !clr_dbe) || (rd_valid && db);
        end
    end

    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R1 wr_valid", WW'(wr_valid), WW'(e_wv));
            chk("R1/R2 wr_word", wr_word, e_ww);
            chk("R3 out_valid", WW'(out_valid), WW'(e_ov));
            chk("R3/R4/R6 out_data", WW'(out_data), WW'(e_od));
            chk("R3/R5 out_chk", WW'(out_chk), WW'(e_oc));
            chk("R4/R5 out_dirty", WW'(out_dirty), WW'(e_dirty));
            chk("R6 out_uncorr", WW'(out_uncorr), WW'(e_unc));
            chk("R7 sbe_status", WW'(sbe_status), WW'(e_sbe));
            chk("R7 dbe_status", WW'(dbe_status), WW'(e_dbe));
            chk("R8 irq_sbe", WW'(irq_sbe), WW'(e_sbe && !mask_sbe));
            chk("R8 irq_dbe", WW'(irq_dbe), WW'(e_dbe && !mask_dbe));
            chk("R9 err_lane", WW'(err_lane), WW'(e_lane));
            chk("R9 err_syn", WW'(err_syn), WW'(e_syn));
        end
    end

    function automatic logic [511:0] rnd_line();
        logic [511:0] d;
        for (int k = 0; k < 16; k++) d[32*k +: 32] = $urandom;
        return d;
    endfunction

    task automatic do_write(input logic [511:0] d);
        @(negedge clk); wr_en = 1; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic do_read(input logic [WW-1:0] w, input logic cs, input logic cd);
        @(negedge clk); rd_valid = 1; rd_word = w; clr_sbe = cs; clr_dbe = cd;
        @(negedge clk); rd_valid = 0; clr_sbe = 0; clr_dbe = 0;
    endtask

    task automatic do_clear();
        @(negedge clk); clr_sbe = 1; clr_dbe = 1;
        @(negedge clk); clr_sbe = 0; clr_dbe = 0;
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            nbad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        logic [WW-1:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R10 reset state at the ports
        chk("R10 reset data path", {wr_word[591:0]}, '0);
        chk("R10 reset outputs", WW'({out_valid, wr_valid, out_data, out_chk, out_dirty, out_uncorr}), '0);
        chk("R10 reset status", WW'({sbe_status, dbe_status, err_lane, err_syn, irq_sbe, irq_dbe}), '0);

        // R1 R2: writes, including all-zero and all-one lines
        do_write('0);
        do_write({512{1'b1}});
        for (int k = 0; k < 4; k++) do_write(rnd_line());
        repeat (2) @(negedge clk);

        // R3 clean reads
        for (int k = 0; k < 3; k++) do_read(build(rnd_line()), 0, 0);

        // R4 single data flip in lane 5, R8 unmasked irq
        w = build(rnd_line()); w[5*64 + 17] ^= 1'b1;
        do_read(w, 0, 0);
        // R8 mask hides irq, status stays
        @(negedge clk); mask_sbe = 1;
        repeat (2) @(negedge clk); mask_sbe = 0;
        // R9 second error does not overwrite the record
        w = build(rnd_line()); w[2*64 + 40] ^= 1'b1;
        do_read(w, 0, 0);
        do_clear();
        // R9 two lanes in one line: lowest lane recorded; R4 multi-lane repair
        w = build(rnd_line()); w[6*64 + 3] ^= 1'b1; w[3*64 + 63] ^= 1'b1;
        do_read(w, 0, 0);
        do_clear();
        // R5 check-bit flips: bit 4 of lane 0, bit 7 of lane 7
        w = build(rnd_line()); w[512 + 4] ^= 1'b1;
        do_read(w, 0, 0);
        w = build(rnd_line()); w[512 + 56 + 7] ^= 1'b1;
        do_read(w, 0, 0);
        do_clear();
        // R6 double error in lane 4 with mask toggle
        w = build(rnd_line()); w[4*64 + 1] ^= 1'b1; w[4*64 + 50] ^= 1'b1;
        do_read(w, 0, 0);
        @(negedge clk); mask_dbe = 1;
        @(negedge clk); mask_dbe = 0;
        // R6 data plus check bit in one lane
        w = build(rnd_line()); w[1*64 + 9] ^= 1'b1; w[512 + 8 + 2] ^= 1'b1;
        do_read(w, 0, 0);
        // R4 R6 mixed line: single in lane 1, double in lane 7
        do_clear();
        w = build(rnd_line()); w[1*64 + 0] ^= 1'b1; w[7*64 + 5] ^= 1'b1; w[7*64 + 6] ^= 1'b1;
        do_read(w, 0, 0);
        // R7 clear together with a new error: error wins
        w = build(rnd_line()); w[0*64 + 30] ^= 1'b1;
        do_read(w, 1, 1);
        do_clear();
        // R4 R5 sweep over lanes and bits
        for (int k = 0; k < 40; k++) begin
            int ln, bt;
            ln = $urandom_range(7);
            bt = $urandom_range(71);
            w = build(rnd_line());
            if (bt < 64) w[ln*64 + bt] ^= 1'b1;
            else         w[512 + ln*8 + (bt - 64)] ^= 1'b1;
            do_read(w, (k % 3) == 0, 0);
        end
        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule